// File: doc/BRIEF.md
# Programmable-Length SPI Master Shift Engine

This block is the serial core of an SPI master. It takes 32-bit entries from a transmit queue, extracts one word of 4 to 32 bits from each, and shifts it out most significant bit first. At the same time it shifts a word in and hands it to a receive queue, right-justified in a 32-bit entry. A start pulse latches the configuration and a word total. The engine then runs words back to back with its active-low select held asserted, and pulses `done_o` after the last word.

The serial clock is derived from the core clock. Each half period lasts `cfg_div_i + 1` core cycles. A fast setting shortens each half period to a single core cycle, but only when the internal loopback path is off. Clock idle level and the sampling edge are selectable. If the transmit queue runs dry before the total is reached, the serial clock stops at its idle level until a new entry arrives.

Top module: `spi_eng`

## Requirements
- R1: The word length is `cfg_bits_m1_i + 1` bits, for values 3 to 31 (4 to 32 bits). Every word uses exactly that many bits and 2×length serial clock edges.
- R2: A transmit entry is read as a container of 1 byte (length ≤ 8), 2 bytes (length ≤ 16) or 4 bytes (otherwise), taken from the top of the entry (bits 31:24, 31:16 or 31:0). The low `length` bits of the container are sent most significant bit first on `mosi_o`.
- R3: Each received word appears on `rx_data_o` in bits length-1:0 with zeros above. It is qualified by a one-cycle `rx_valid_o` while the select is asserted, and never in the same cycle as `done_o` or `tx_ready_o`.
- R4: With the select deasserted, `sclk_o` equals the polarity setting (`cfg_cpol_i` = 1 means idle high). The first edge of every bit moves the clock away from that level.
- R5: With `cfg_in_first_i` = 1, the first bit is on `mosi_o` before the first edge, input is sampled on the first edge of each bit, and output changes on the second. With it 0, output changes on the first edge and input is sampled on the second.
- R6: With `cfg_loop_i` = 1, the received word is the transmitted word and `miso_i` has no effect.
- R7: With `cfg_fast_i` = 1 and loopback off, every serial clock half period is one core cycle. With loopback on, the fast setting is ignored.
- R8: Otherwise every half period within a word is `cfg_div_i + 1` core cycles.
- R9: When the transmit queue is empty and words remain, `sclk_o` stays at its idle level and the select stays asserted until an entry arrives.
- R10: After `cfg_count_i` words, the engine pulses `done_o` for one cycle with the select released and `words_done_o` equal to the total. A total of 0 produces `done_o` with no clock edges.
- R11: After reset, the select is deasserted, `busy_o`, `rx_valid_o` and `done_o` are low, and `sclk_o` follows the polarity setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer; ignored while busy |
| cfg_bits_m1_i | input | 5 | Word length minus one |
| cfg_cpol_i | input | 1 | Serial clock idles high when 1 |
| cfg_in_first_i | input | 1 | Sample on first edge of each bit |
| cfg_loop_i | input | 1 | Internal loopback of serial output to input |
| cfg_fast_i | input | 1 | One-cycle half period when loopback is off |
| cfg_div_i | input | DIV_W | Half period minus one, in core cycles |
| cfg_count_i | input | CNT_W | Words in the transfer |
| tx_data_i | input | 32 | Transmit queue head entry |
| tx_valid_i | input | 1 | Transmit queue not empty |
| tx_ready_o | output | 1 | Entry taken when high together with valid |
| rx_data_o | output | 32 | Received word, right-justified |
| rx_valid_o | output | 1 | Received word strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Select, active low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished strobe |
| words_done_o | output | CNT_W | Words completed in this transfer |

## Verification
A wrong edge counter or a wrong phase decode shows up on the very next received word. The slave model captures a word other than the packed container, and `rx_data_o` differs from the slave's word. The error is visible within 2×length half periods of the fault. A divider or fast-mode error appears as a half-period gap other than the expected one between the first two edges of a word. A remaining-word or stall fault shows as serial clock edges with an empty queue, or as a wrong `words_done_o` at `done_o`, within one word time.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int unsigned ENTRY_W = 32;

  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_WEND, ST_DONE} st_e;

  function automatic logic [ENTRY_W-1:0] word_mask(input logic [4:0] bm1);
    return {ENTRY_W{1'b1}} >> (5'd31 - bm1);
  endfunction

  // container is 1, 2 or 4 bytes taken from the top of the entry
  function automatic logic [ENTRY_W-1:0] tx_extract(input logic [ENTRY_W-1:0] entry,
                                                    input logic [4:0] bm1);
    logic [ENTRY_W-1:0] c;
    if (bm1 < 5'd8)       c = {24'h0, entry[31:24]};
    else if (bm1 < 5'd16) c = {16'h0, entry[31:16]};
    else                  c = entry;
    return c & word_mask(bm1);
  endfunction
endpackage

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_m1_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == half_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_eng_shreg.sv
module spi_eng_shreg import spi_eng_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ENTRY_W-1:0] tx_word_i,
  input  logic [4:0]         bm1_i,
  input  logic               launch_i,
  input  logic               sample_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic [ENTRY_W-1:0] rx_word_o
);
  logic [ENTRY_W-1:0] tx_q, rx_q;

  assign sdo_o     = tx_q[bm1_i];
  assign rx_word_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= tx_word_i;
      rx_q <= '0;
    end else begin
      if (launch_i) tx_q <= tx_q << 1;
      if (sample_i) rx_q <= {rx_q[ENTRY_W-2:0], sdi_i};
    end
  end
endmodule

// File: rtl/spi_eng.sv
module spi_eng import spi_eng_pkg::*; #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [4:0]         cfg_bits_m1_i,
  input  logic               cfg_cpol_i,
  input  logic               cfg_in_first_i,
  input  logic               cfg_loop_i,
  input  logic               cfg_fast_i,
  input  logic [DIV_W-1:0]   cfg_div_i,
  input  logic [CNT_W-1:0]   cfg_count_i,
  input  logic [ENTRY_W-1:0] tx_data_i,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  output logic [ENTRY_W-1:0] rx_data_o,
  output logic               rx_valid_o,
  output logic               sclk_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic               cs_no,
  output logic               busy_o,
  output logic               done_o,
  output logic [CNT_W-1:0]   words_done_o
);
  st_e              st_q;
  logic [4:0]       bm1_q;
  logic             cpol_q, infirst_q, loop_q, fast_q, sclk_q;
  logic [DIV_W-1:0] div_q, half_m1;
  logic [CNT_W-1:0] cnt_q, rem_q, words_q;
  logic [5:0]       edge_q;
  logic             tick, lead, last_edge, sample_ev, launch_ev, load_ev, sdi, sdo;

  // fast mode only counts when loopback is off
  assign half_m1   = (fast_q && !loop_q) ? '0 : div_q;
  assign lead      = ~edge_q[0];
  assign last_edge = (edge_q == {bm1_q, 1'b1});
  assign sample_ev = tick && (infirst_q ? lead : !lead);
  assign launch_ev = tick && !last_edge &&
                     (infirst_q ? !lead : (lead && edge_q != '0));
  assign tx_ready_o = (st_q == ST_LOAD) && (rem_q != '0);
  assign load_ev    = tx_ready_o && tx_valid_i;
  assign sdi        = loop_q ? sdo : miso_i;

  spi_eng_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (st_q == ST_SHIFT),
    .half_m1_i (half_m1),
    .tick_o    (tick)
  );

  spi_eng_shreg u_sh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_ev),
    .tx_word_i (tx_extract(tx_data_i, bm1_q)),
    .bm1_i     (bm1_q),
    .launch_i  (launch_ev),
    .sample_i  (sample_ev),
    .sdi_i     (sdi),
    .sdo_o     (sdo),
    .rx_word_o (rx_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bm1_q     <= 5'd7;
      cpol_q    <= 1'b0;
      infirst_q <= 1'b0;
      loop_q    <= 1'b0;
      fast_q    <= 1'b0;
      div_q     <= '0;
      cnt_q     <= '0;
      rem_q     <= '0;
      words_q   <= '0;
      edge_q    <= '0;
      sclk_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          bm1_q     <= cfg_bits_m1_i;
          cpol_q    <= cfg_cpol_i;
          infirst_q <= cfg_in_first_i;
          loop_q    <= cfg_loop_i;
          fast_q    <= cfg_fast_i;
          div_q     <= cfg_div_i;
          cnt_q     <= cfg_count_i;
          rem_q     <= cfg_count_i;
          words_q   <= '0;
          sclk_q    <= cfg_cpol_i;
          st_q      <= ST_LOAD;
        end
        ST_LOAD: begin
          if (rem_q == '0) st_q <= ST_DONE;
          else if (tx_valid_i) begin
            rem_q  <= rem_q - 1'b1;
            edge_q <= '0;
            st_q   <= ST_SHIFT;
          end
        end
        ST_SHIFT: if (tick) begin
          sclk_q <= ~sclk_q;
          edge_q <= edge_q + 1'b1;
          if (last_edge) st_q <= ST_WEND;
        end
        ST_WEND: begin
          words_q <= words_q + 1'b1;
          st_q    <= ST_LOAD;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o       = (st_q == ST_IDLE) ? cfg_cpol_i : sclk_q;
  assign mosi_o       = sdo;
  assign cs_no        = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_DONE);
  assign rx_valid_o   = (st_q == ST_WEND);
  assign words_done_o = words_q;
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk import spi_eng_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input st_e              st_i,
  input logic             cpol_i,
  input logic [CNT_W-1:0] total_i,
  input logic             sclk_i,
  input logic             cs_ni,
  input logic             rx_valid_i,
  input logic             done_i,
  input logic             tx_ready_i,
  input logic [CNT_W-1:0] words_i
);
  p_rx_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |-> !cs_ni);
  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_valid_i, done_i, tx_ready_i}));
  p_stall_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_LOAD) |-> (sclk_i == cpol_i) && !cs_ni);
  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_LOAD) && !tx_ready_i |=> $stable(sclk_i));
  p_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> words_i == total_i);
  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> cs_ni);
  p_idle_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_DONE) |-> sclk_i == cpol_i);
endmodule

bind spi_eng spi_eng_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .st_i       (st_q),
  .cpol_i     (cpol_q),
  .total_i    (cnt_q),
  .sclk_i     (sclk_o),
  .cs_ni      (cs_no),
  .rx_valid_i (rx_valid_o),
  .done_i     (done_o),
  .tx_ready_i (tx_ready_o),
  .words_i    (words_done_o)
);

// File: tb/spi_eng_test.sv
`timescale 1ns/1ps
module spi_eng_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  bm1 = 5'd7;
  logic        cpol = 1'b0, inf = 1'b0, lpb = 1'b0, fast = 1'b0;
  logic [7:0]  div = 8'd0;
  logic [15:0] count = 16'd1;
  logic [31:0] tx_data, rx_data;
  logic        tx_valid, tx_ready, rx_valid, sclk, mosi, cs_n, busy, done;
  logic        miso = 1'b0;
  logic [15:0] words_done;

  always #4 clk = ~clk;

  spi_eng uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_bits_m1_i(bm1),
    .cfg_cpol_i(cpol), .cfg_in_first_i(inf), .cfg_loop_i(lpb), .cfg_fast_i(fast),
    .cfg_div_i(div), .cfg_count_i(count), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n), .busy_o(busy), .done_o(done),
    .words_done_o(words_done)
  );

  // transmit queue model
  logic [31:0] fifo [8];
  int wr = 0, rd = 0;
  logic clr = 1'b0;
  assign tx_valid = (rd < wr);
  assign tx_data  = fifo[rd[2:0]];
  always @(posedge clk) begin
    if (clr) rd <= 0;
    else if (tx_valid && tx_ready) rd <= rd + 1;
  end

  // slave and monitor model
  logic [31:0] sl_words [8];
  logic [31:0] sl_log [8];
  logic [31:0] rx_log [8];
  logic [31:0] sl_sh, cap;
  int sl_idx, n_sl, n_rx, n_done, e_cnt, e_total, gap, gap_min, gap_max;
  logic prev_sclk;
  always @(negedge clk) begin
    automatic int nb = int'(bm1) + 1;
    if (clr) begin
      sl_idx = 0; n_sl = 0; n_rx = 0; n_done = 0; e_cnt = 0; e_total = 0;
      gap = 0; gap_min = 999; gap_max = 0; cap = 0; prev_sclk = sclk;
      sl_sh = sl_words[0]; miso = sl_sh[nb-1];
    end else begin
      gap = gap + 1;
      if (rx_valid) begin rx_log[n_rx[2:0]] = rx_data; n_rx = n_rx + 1; end
      if (done) n_done = n_done + 1;
      if (cs_n) begin
        e_cnt = 0; cap = 0; sl_sh = sl_words[sl_idx[2:0]]; miso = sl_sh[nb-1];
      end else if (sclk != prev_sclk) begin
        automatic logic lead = (e_cnt % 2 == 0);
        e_total = e_total + 1;
        if (e_cnt > 0) begin
          if (gap < gap_min) gap_min = gap;
          if (gap > gap_max) gap_max = gap;
        end
        if (inf ? lead : !lead) cap = (cap << 1) | {31'd0, mosi};
        if (e_cnt == 2*nb-1) begin
          sl_log[n_sl[2:0]] = cap; n_sl = n_sl + 1; cap = 0; e_cnt = 0;
          sl_idx = sl_idx + 1; sl_sh = sl_words[sl_idx[2:0]]; miso = sl_sh[nb-1];
        end else begin
          if (inf ? !lead : (lead && e_cnt != 0)) begin
            sl_sh = sl_sh << 1; miso = sl_sh[nb-1];
          end
          e_cnt = e_cnt + 1;
        end
      end
      gap = (sclk != prev_sclk) ? 0 : gap;
      prev_sclk = sclk;
    end
  end

  int n_cmp = 0, n_err = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prep(input logic [4:0] b, input logic cp, input logic fi, input logic lb,
                      input logic fs, input logic [7:0] dv, input logic [15:0] cn);
    bm1 = b; cpol = cp; inf = fi; lpb = lb; fast = fs; div = dv; count = cn;
    wr = 0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic go();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    for (int i = 0; i < 5000 && n_done == 0; i++) @(negedge clk);
    chk(req, n_done, 1);
  endtask

  typedef struct packed {
    logic [4:0]  b;
    logic        cp, fi, lb, fs;
    logic [7:0]  dv;
    logic [31:0] entry, sword, exp_tx, exp_rx;
    logic [7:0]  hp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{5'd7,  1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 32'hA5000000, 32'h0000003C, 32'h000000A5, 32'h0000003C, 8'd2},
    '{5'd15, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 32'h12345678, 32'h0000BEEF, 32'h00001234, 32'h0000BEEF, 8'd1},
    '{5'd31, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2, 32'hDEADBEEF, 32'h0F1E2D3C, 32'hDEADBEEF, 32'h0F1E2D3C, 8'd3},
    '{5'd3,  1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 32'h9A000000, 32'h00000005, 32'h0000000A, 32'h00000005, 8'd1},
    '{5'd11, 1'b0, 1'b1, 1'b0, 1'b1, 8'd3, 32'hABCD0000, 32'h00000123, 32'h00000BCD, 32'h00000123, 8'd1},
    '{5'd23, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1, 32'h11223344, 32'h00C0FFEE, 32'h00223344, 32'h00C0FFEE, 8'd2},
    '{5'd8,  1'b1, 1'b0, 1'b1, 1'b1, 8'd1, 32'h01550000, 32'h000000AA, 32'h00000155, 32'h00000155, 8'd2},
    '{5'd4,  1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 32'h15000000, 32'h0000000A, 32'h00000015, 32'h00000015, 8'd1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 cs_n", cs_n, 1);
    chk("R11 busy", busy, 0);
    chk("R11 rx_valid/done", {rx_valid, done}, 0);
    chk("R11 sclk", sclk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cpol = 1'b1;
    @(negedge clk);
    chk("R11 sclk follows polarity", sclk, 1);

    // table: one word per vector (R1 R2 R3 R5 R6 R7 R8)
    foreach (VECS[k]) begin
      sl_words[0] = VECS[k].sword;
      prep(VECS[k].b, VECS[k].cp, VECS[k].fi, VECS[k].lb, VECS[k].fs, VECS[k].dv, 16'd1);
      fifo[0] = VECS[k].entry; wr = 1;
      go();
      wait_done("R10 done");
      chk("R2 R5 mosi word", sl_log[0], VECS[k].exp_tx);
      chk("R3 R6 rx word", rx_log[0], VECS[k].exp_rx);
      chk("R1 edge count", e_total, 2 * (int'(VECS[k].b) + 1));
      chk("R7 R8 half period", {gap_min[15:0], gap_max[15:0]}, {8'd0, VECS[k].hp, 8'd0, VECS[k].hp});
      chk("R4 idle level", {cs_n, sclk}, {1'b1, VECS[k].cp});
      chk("R10 words", words_done, 1);
    end

    // R9 stall with empty queue, three words
    sl_words[0] = 32'h11; sl_words[1] = 32'h22; sl_words[2] = 32'h33;
    prep(5'd7, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 16'd3);
    fifo[0] = 32'hC1000000; fifo[1] = 32'hC2000000; fifo[2] = 32'hC3000000; wr = 1;
    go();
    for (int i = 0; i < 500 && n_rx == 0; i++) @(negedge clk);
    begin
      automatic int bad = 0;
      automatic int e0 = e_total;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (sclk !== 1'b1 || cs_n !== 1'b0) bad++;
      end
      chk("R9 clock held while queue empty", bad, 0);
      chk("R9 no edges while queue empty", e_total, e0);
    end
    wr = 3;
    wait_done("R9 resumes to done");
    chk("R10 three words", words_done, 3);
    chk("R3 rx count", n_rx, 3);
    chk("R2 word 2", sl_log[1], 32'hC2);
    chk("R3 word 3", rx_log[2], 32'h33);

    // R10 zero total
    prep(5'd7, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 16'd0);
    go();
    wait_done("R10 zero total done");
    chk("R10 zero total edges", e_total, 0);
    chk("R10 zero total words", words_done, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_err + 1);
    $finish;
  end
endmodule